// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Pin Override

This block is one 8-bit general-purpose I/O port as it sits between a register file and the pad ring. Software owns two byte-wide registers: a direction register (a 1 makes the pin an output) and a port register. On an output pin the port bit is the driven value. On an input pin the port bit turns on the pull-up. Every pad input passes through a two-flop synchronizer before software or a peripheral sees it.

Above the software registers sits an override layer for the four low pins. Bit 3 serves as the SPI data line: the master drives its value, and the slave reads it. Bit 2 is the SPI slave-select input. Bits 1 to 3 carry timer compare or PWM outputs. Bit 0 can output a divided system clock. Each pin has its own override rules. The SPI slave forces bits 3 and 2 to inputs but leaves their pull-ups to software. The clock output takes over both direction and value on bit 0, and it does not depend on reset. The SPI, the timers and any pin-change logic are outside this block.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted and just after it is released, the direction and port registers are zero: padOe, padPullUp and pinRead are all 0, except on bit 0 when R10 applies.
- R2: A one-cycle dirWrEn pulse loads all bits of dirWrData into the direction register at the next rising clock edge. With no override active, padOe then equals the written byte.
- R3: A one-cycle portWrEn pulse loads portWrData at the next rising clock edge. On a pin with no value override, padOut equals its port bit.
- R4: A change on padIn is absent from pinRead after one rising edge and present after the second.
- R5: With spiEn=1 and spiMaster=0, padOe[3] and padOe[2] are 0 whatever the direction bits hold.
- R6: With spiEn=1 and spiMaster=1, padOe[3:2] follow the direction bits and padOut[3] equals spiMosiOut. The SPI value takes priority over a compare output on bit 3.
- R7: On a pin forced to input by the SPI slave, padPullUp equals that pin's port bit.
- R8: On every pin, padPullUp is 0 while padOe is 1, and equals the port bit while padOe is 0.
- R9: When cmpEn[j]=1, padOut[j+1] equals cmpVal[j] (j=0..2 maps to bits 1..3). padOe on those bits still comes from the direction register, so the compare value reaches the pad only on a pin set as output.
- R10: With clkOutFuse=1, padOe[0]=1, padOut[0]=clkDiv and padPullUp[0]=0, whatever the bit-0 register values are and also during reset.
- R11: spiSlaveSel is 1 only when spiEn=1, spiMaster=0 and synchronized bit 2 (pinRead[2]) is 0. spiMosiIn equals pinRead[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirWrEn | input | 1 | Direction register write strobe |
| dirWrData | input | 8 | Direction register write data |
| portWrEn | input | 1 | Port register write strobe |
| portWrData | input | 8 | Port register write data |
| spiEn | input | 1 | SPI enabled |
| spiMaster | input | 1 | SPI in master mode (0 = slave) |
| spiMosiOut | input | 1 | Master data value for bit 3 |
| cmpEn | input | 3 | Compare-output enables for bits 1..3 |
| cmpVal | input | 3 | Compare-output values for bits 1..3 |
| clkOutFuse | input | 1 | Enables the clock output on bit 0 |
| clkDiv | input | 1 | Divided system clock |
| padIn | input | 8 | Raw pad input levels |
| padOe | output | 8 | Pad output enable |
| padOut | output | 8 | Pad output value, driven only where padOe is 1 |
| padPullUp | output | 8 | Pad pull-up enable |
| pinRead | output | 8 | Synchronized pad inputs |
| spiMosiIn | output | 1 | Synchronized bit 3 for the SPI slave |
| spiSlaveSel | output | 1 | SPI slave selected |

## Verification
Direction and port bytes with mixed bit patterns (F0/A5, FF/0C, 0E) show whether output enable, value and pull-up are decoded per bit. The same register contents are applied under the slave, master, compare and clock-out modes, so each override shows up only as a change on its own pins. Bit 3 is tried with master and compare active together, which exposes the priority order. The clock value is toggled during reset and after it. A pad change is sampled one edge and two edges after it happens, which measures the synchronizer depth, and slave-select is sampled with SS low and then high.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  // pins of the port that carry peripheral overrides
  localparam int OVR_PINS = 4;
  localparam int PIN_CLKO = 0;
  localparam int PIN_CMP0 = 1;   // first compare pin, compare j sits on PIN_CMP0 + j
  localparam int CMP_CNT  = 3;
  localparam int PIN_SS   = 2;
  localparam int PIN_MOSI = 3;

  typedef struct packed {
    logic                dirLoad;
    logic                portLoad;
    logic [OVR_PINS-1:0] forceOe;   // pin driven regardless of direction bit
    logic [OVR_PINS-1:0] forceIn;   // pin held as input regardless of direction bit
    logic [OVR_PINS-1:0] valOvrEn;  // output value taken from a peripheral
    logic [OVR_PINS-1:0] valOvr;
  } ovrStrobes_t;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
(
  input  logic               dirWrEn,
  input  logic               portWrEn,
  input  logic               spiEn,
  input  logic               spiMaster,
  input  logic               spiMosiOut,
  input  logic [CMP_CNT-1:0] cmpEn,
  input  logic [CMP_CNT-1:0] cmpVal,
  input  logic               clkOutFuse,
  input  logic               clkDiv,
  input  logic               ssSync,
  input  logic               mosiSync,
  output ovrStrobes_t        strb,
  output logic               spiSlaveSel,
  output logic               spiMosiIn
);
  logic slaveMode, masterMode;
  assign slaveMode  = spiEn & ~spiMaster;
  assign masterMode = spiEn &  spiMaster;

  always_comb begin
    strb          = '0;
    strb.dirLoad  = dirWrEn;
    strb.portLoad = portWrEn;
    // lowest priority: timer compare values
    for (int j = 0; j < CMP_CNT; j++) begin
      strb.valOvrEn[PIN_CMP0 + j] = cmpEn[j];
      strb.valOvr[PIN_CMP0 + j]   = cmpVal[j];
    end
    // SPI master value wins over compare on the data pin
    if (masterMode) begin
      strb.valOvrEn[PIN_MOSI] = 1'b1;
      strb.valOvr[PIN_MOSI]   = spiMosiOut;
    end
    // SPI slave: data and select pins become inputs
    if (slaveMode) begin
      strb.forceIn[PIN_MOSI] = 1'b1;
      strb.forceIn[PIN_SS]   = 1'b1;
    end
    // clock output owns bit 0 entirely; independent of reset
    if (clkOutFuse) begin
      strb.forceOe[PIN_CLKO]  = 1'b1;
      strb.valOvrEn[PIN_CLKO] = 1'b1;
      strb.valOvr[PIN_CLKO]   = clkDiv;
    end
  end

  assign spiSlaveSel = slaveMode & ~ssSync;
  assign spiMosiIn   = mosiSync;
endmodule

// File: rtl/gpio_ovr_data.sv
module gpio_ovr_data
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ovrStrobes_t      strb,
  input  logic [WIDTH-1:0] dirWrData,
  input  logic [WIDTH-1:0] portWrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullUp,
  output logic [WIDTH-1:0] pinRead
);
  logic [WIDTH-1:0] dirReg, portReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      portReg <= '0;
    end else begin
      if (strb.dirLoad)  dirReg  <= dirWrData;
      if (strb.portLoad) portReg <= portWrData;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < OVR_PINS) begin : g_ovr
      assign padOe[i]  = strb.forceOe[i] | (dirReg[i] & ~strb.forceIn[i]);
      assign padOut[i] = strb.valOvrEn[i] ? strb.valOvr[i] : portReg[i];

      // R7: a forced input keeps its pull-up under software control
      p_forced_pullup_r7: assert property (@(posedge clk) disable iff (!rstN)
        strb.forceIn[i] |-> padPullUp[i] == portReg[i]);
    end else begin : g_plain
      assign padOe[i]  = dirReg[i];
      assign padOut[i] = portReg[i];
    end
  end

  assign padPullUp = portReg & ~padOe;

  gpio_ovr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din (padIn),
    .dout(pinRead)
  );

  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirLoad |=> dirReg == $past(dirWrData));

  p_port_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.portLoad |=> portReg == $past(portWrData));

  // R9: compare pins never gain an output enable on their own
  p_cmp_dir_r9: assert property (@(posedge clk) disable iff (!rstN)
    padOe[PIN_CMP0] == dirReg[PIN_CMP0]);
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,   // must be at least OVR_PINS
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dirWrEn,
  input  logic [WIDTH-1:0]   dirWrData,
  input  logic               portWrEn,
  input  logic [WIDTH-1:0]   portWrData,
  input  logic               spiEn,
  input  logic               spiMaster,
  input  logic               spiMosiOut,
  input  logic [CMP_CNT-1:0] cmpEn,
  input  logic [CMP_CNT-1:0] cmpVal,
  input  logic               clkOutFuse,
  input  logic               clkDiv,
  input  logic [WIDTH-1:0]   padIn,
  output logic [WIDTH-1:0]   padOe,
  output logic [WIDTH-1:0]   padOut,
  output logic [WIDTH-1:0]   padPullUp,
  output logic [WIDTH-1:0]   pinRead,
  output logic               spiMosiIn,
  output logic               spiSlaveSel
);
  ovrStrobes_t strb;

  gpio_ovr_ctrl i_ctrl (
    .dirWrEn    (dirWrEn),
    .portWrEn   (portWrEn),
    .spiEn      (spiEn),
    .spiMaster  (spiMaster),
    .spiMosiOut (spiMosiOut),
    .cmpEn      (cmpEn),
    .cmpVal     (cmpVal),
    .clkOutFuse (clkOutFuse),
    .clkDiv     (clkDiv),
    .ssSync     (pinRead[PIN_SS]),
    .mosiSync   (pinRead[PIN_MOSI]),
    .strb       (strb),
    .spiSlaveSel(spiSlaveSel),
    .spiMosiIn  (spiMosiIn)
  );

  gpio_ovr_data #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dirWrData (dirWrData),
    .portWrData(portWrData),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp),
    .pinRead   (pinRead)
  );

  p_slave_forces_in_r5: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && !spiMaster) |-> (padOe[PIN_MOSI] == 1'b0 && padOe[PIN_SS] == 1'b0));

  p_master_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && spiMaster) |-> padOut[PIN_MOSI] == spiMosiOut);

  p_pullup_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullUp) == '0);

  // R10: holds in and out of reset, so it is not gated by rstN
  always_comb begin
    if (clkOutFuse) begin
      p_clock_out_r10: assert (padOe[PIN_CLKO] && padOut[PIN_CLKO] == clkDiv
                               && !padPullUp[PIN_CLKO]);
    end
  end
endmodule

// File: tb/test_gpio_ovr_port.sv
module test_gpio_ovr_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dirWrEn = 1'b0, portWrEn = 1'b0;
  logic [7:0] dirWrData = '0, portWrData = '0;
  logic       spiEn = 1'b0, spiMaster = 1'b0, spiMosiOut = 1'b0;
  logic [2:0] cmpEn = '0, cmpVal = '0;
  logic       clkOutFuse = 1'b1, clkDiv = 1'b1;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullUp, pinRead;
  logic       spiMosiIn, spiSlaveSel;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mDir = '0, mPort = '0;   // bench copy of software registers

  typedef struct {
    string      tag;
    logic [7:0] oe, out, pu, rd;
    logic       sel, mosi;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;   // 50 MHz

  gpio_ovr_port i_gpio_ovr_port (
    .clk(clk), .rstN(rstN),
    .dirWrEn(dirWrEn), .dirWrData(dirWrData),
    .portWrEn(portWrEn), .portWrData(portWrData),
    .spiEn(spiEn), .spiMaster(spiMaster), .spiMosiOut(spiMosiOut),
    .cmpEn(cmpEn), .cmpVal(cmpVal),
    .clkOutFuse(clkOutFuse), .clkDiv(clkDiv), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp), .pinRead(pinRead),
    .spiMosiIn(spiMosiIn), .spiSlaveSel(spiSlaveSel)
  );

  // expected pad state from the requirements
  task automatic push(input string tag, input logic [7:0] rd);
    exp_t e;
    e.tag = tag;
    e.oe  = mDir;
    e.out = mPort;
    for (int j = 0; j < 3; j++) if (cmpEn[j]) e.out[j+1] = cmpVal[j];   // R9
    if (spiEn && spiMaster) e.out[3] = spiMosiOut;                       // R6
    if (spiEn && !spiMaster) e.oe[3:2] = 2'b00;                          // R5
    e.pu = mPort & ~e.oe;                                                // R7, R8
    if (clkOutFuse) begin e.oe[0] = 1'b1; e.out[0] = clkDiv; e.pu[0] = 1'b0; end // R10
    e.rd   = rd;
    e.sel  = spiEn && !spiMaster && !rd[2];                              // R11
    e.mosi = rd[3];
    q.push_back(e);
  endtask

  task automatic cmp8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares at the falling edge, away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp8(e.tag, "padOe", padOe, e.oe);
        cmp8(e.tag, "padOut", padOut, e.out);
        cmp8(e.tag, "padPullUp", padPullUp, e.pu);
        cmp8(e.tag, "pinRead", pinRead, e.rd);
        cmp8(e.tag, "spiSlaveSel", {7'b0, spiSlaveSel}, {7'b0, e.sel});
        cmp8(e.tag, "spiMosiIn", {7'b0, spiMosiIn}, {7'b0, e.mosi});
      end
    end
  end

  task automatic tick(); @(posedge clk); #5; endtask
  task automatic settle(input int n); repeat (n) @(posedge clk); endtask

  task automatic wrDir(input logic [7:0] d);
    tick(); dirWrEn = 1'b1; dirWrData = d;
    @(posedge clk); mDir = d; #5 dirWrEn = 1'b0; dirWrData = ~d;
  endtask
  task automatic wrPort(input logic [7:0] d);
    tick(); portWrEn = 1'b1; portWrData = d;
    @(posedge clk); mPort = d; #5 portWrEn = 1'b0; portWrData = ~d;
  endtask

  initial begin
    // R1 and R10: reset state with the clock output active
    #5 push("R1_R10 reset clkDiv=1", 8'h00);
    #20 clkDiv = 1'b0; push("R10 reset clkDiv=0", 8'h00);
    settle(2); tick();
    rstN = 1'b1; clkOutFuse = 1'b0;
    push("R1 after release", 8'h00);

    // R2, R3: byte-wide writes visible after one edge
    wrDir(8'hF0);  push("R2 dir F0", 8'h00);
    wrPort(8'hA5); push("R3 R8 port A5", 8'h00);

    // R4: synchronizer depth
    tick(); padIn = 8'h3C;
    settle(1); push("R4 one edge", 8'h00);
    tick(); push("R4 two edges", 8'h3C);

    // R5, R7, R11: SPI slave with SS low then high
    wrDir(8'hFF); wrPort(8'h0C);
    tick(); spiEn = 1'b1; spiMaster = 1'b0; padIn = 8'h08;
    settle(2); push("R5 R7 R11 slave SS low", 8'h08);
    tick(); padIn = 8'h04;
    settle(2); push("R11 slave SS high", 8'h04);

    // R6: master value wins over compare on bit 3
    tick(); spiMaster = 1'b1; spiMosiOut = 1'b1; cmpEn = 3'b100; cmpVal = 3'b000;
    push("R6 master mosi=1", 8'h04);
    tick(); spiMosiOut = 1'b0; cmpVal = 3'b100;
    push("R6 master mosi=0 over compare", 8'h04);

    // R9: compare values with direction cleared then set
    tick(); spiEn = 1'b0; cmpEn = 3'b111; cmpVal = 3'b010;
    wrDir(8'h00); wrPort(8'h0E); push("R9 compare dir=0", 8'h04);
    wrDir(8'h0E); push("R9 R8 compare dir=1", 8'h04);
    tick(); cmpVal = 3'b101; push("R9 compare 101", 8'h04);

    // R10: clock output overrides bit-0 registers
    tick(); cmpEn = 3'b000;
    wrDir(8'h00); wrPort(8'h01);
    push("R8 input pullup", 8'h04);
    tick(); clkOutFuse = 1'b1; clkDiv = 1'b1; push("R10 fuse clk=1", 8'h04);
    tick(); clkDiv = 1'b0; push("R10 fuse clk=0", 8'h04);

    settle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule